// File: doc/BRIEF.md
# Scanline Edge-Counting Interrupt Timer

This block raises an interrupt after a programmable number of scanlines. It counts them from the rising edges of the video address line A12, which pulses once per rendered line. A CPU programs the timer with four write-only commands: set the reload value, clear the counter, acknowledge and disable, and enable. The counter cannot be read back. The interrupt output is active low. Once raised, it stays low until the CPU acknowledges it.

A12 arrives asynchronous to the system clock. It passes through a two-flop synchronizer. A low-time filter then rejects short glitches, so a rise counts only after the line has been low for a set number of clocks. Reload is deferred. The reload value is copied into the counter only on the edge after the counter has reached zero or been cleared. A reload value of N therefore gives an interrupt every N+1 edges. A reload value of zero gives one last interrupt and then no more.

Top module: `scanline_irq_timer`

## Requirements
- R1: After reset, `irq_n` is 1. The counter, the reload value and the enable are all cleared, so once reset is released an enable followed by edges raises no interrupt until a nonzero reload value is written.
- R2: The counter changes only on a filtered rising edge of `ppu_a12`. A falling edge, or a long low time, has no effect.
- R3: On an edge where the counter is zero, the counter is loaded with the reload value instead of being decremented.
- R4: A write with `cpu_addr[15:13]`=3'b110 and `cpu_addr[0]`=0 stores `cpu_wdata` as the reload value and leaves the counter alone. The new value is used at the next reload.
- R5: A write with `cpu_addr[15:13]`=3'b110 and `cpu_addr[0]`=1 forces the counter to zero, whatever the data, so the next edge reloads it.
- R6: When the counter is decremented from 1 to 0 while the interrupt is enabled, the interrupt flag is set. For reload value N, this happens every N+1 edges, and counting continues without end.
- R7: `irq_n` stays 0 until a write with `cpu_addr[15:13]`=3'b111 and `cpu_addr[0]`=0. That write clears the flag and disables interrupts, whatever the data, and does not change the counter.
- R8: A write with `cpu_addr[15:13]`=3'b111 and `cpu_addr[0]`=1 enables interrupts, whatever the data, without changing the counter. While interrupts are disabled, reaching zero does not raise `irq_n`.
- R9: With a reload value of 0, the counter gives one interrupt when it next reaches zero. Later reloads of 0 give none, until a nonzero value is written.
- R10: A rise of `ppu_a12` counts only if the synchronized level was low for at least `MIN_LOW` clocks before it. Shorter low pulses are ignored.
- R11: Only `cpu_addr[15:13]` and `cpu_addr[0]` are decoded. Writes to any other region are ignored, and the remaining address bits may take any value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| cpu_addr | input | ADDR_W | CPU write address |
| cpu_wdata | input | CNT_W | CPU write data |
| ppu_a12 | input | 1 | Asynchronous video address line A12 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `cpu_wr` is a clean single-clock strobe. They also assume that `ppu_a12` edges are widely spaced compared with the synchronizer and filter delays. The stimulus drives every write for exactly one clock, at the falling clock edge. It holds A12 low for more than `MIN_LOW` plus the synchronizer depth before each counted rise, and holds it high long enough for the counter to update before the next stimulus step. Glitches are created on purpose only in the filter test, where the low time is kept below `MIN_LOW`.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

    // Region codes on the top three address bits
    localparam logic [2:0] REGION_COUNT = 3'b110;
    localparam logic [2:0] REGION_IRQ   = 3'b111;

    // Decoded write commands, at most one per cycle
    typedef struct packed {
        logic set_reload;
        logic clear_count;
        logic irq_ack;
        logic irq_enable;
    } cmd_t;

endpackage

// File: rtl/scanirq_decode.sv
module scanirq_decode #(
    parameter int ADDR_W = 16
) (
    input  logic                      wr_i,
    input  logic [ADDR_W-1:0]         addr_i,
    output scanirq_pkg::cmd_t         cmd_o
);
    import scanirq_pkg::*;

    logic [2:0] region;
    logic       sel_odd;
    logic       unused_addr_bits;

    assign region           = addr_i[ADDR_W-1 -: 3];
    assign sel_odd          = addr_i[0];
    assign unused_addr_bits = ^addr_i[ADDR_W-4:1];

    always_comb begin
        cmd_o = '0;
        if (wr_i) begin
            unique case (region)
                REGION_COUNT: begin
                    cmd_o.set_reload  = ~sel_odd;
                    cmd_o.clear_count =  sel_odd;
                end
                REGION_IRQ: begin
                    cmd_o.irq_ack    = ~sel_odd;
                    cmd_o.irq_enable =  sel_odd;
                end
                default: cmd_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/scanirq_edge_filter.sv
module scanirq_edge_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic rise_o
);
    localparam int LOW_W = $clog2(MIN_LOW + 1);
    localparam logic [LOW_W-1:0] LOW_LIMIT = LOW_W'(MIN_LOW);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [LOW_W-1:0]       low_run;
        logic                   rise;
    } filt_t;

    filt_t st_d, st_q;
    logic  level;

    assign level = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d = st_q;
        // shift chain: stage 0 takes the raw pin
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], line_i};
        // saturating count of consecutive low samples
        if (!level) begin
            if (st_q.low_run != LOW_LIMIT)
                st_d.low_run = st_q.low_run + 1'b1;
        end else begin
            st_d.low_run = '0;
        end
        // accept the rise only after a long enough low phase
        st_d.rise = level && (st_q.low_run >= LOW_LIMIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.rise;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rise |=> !st_q.rise);  // R10

    AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.low_run == '0 && level) |=> !st_q.rise);  // R10

endmodule

// File: rtl/scanirq_counter.sv
module scanirq_counter #(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               edge_i,
    input  scanirq_pkg::cmd_t  cmd_i,
    input  logic [CNT_W-1:0]   data_i,
    output logic               flag_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic             enable;
        logic             flag;
    } ctr_t;

    ctr_t st_d, st_q;
    logic hit_zero;

    always_comb begin
        st_d     = st_q;
        hit_zero = 1'b0;

        if (cmd_i.set_reload)
            st_d.reload = data_i;

        if (cmd_i.clear_count) begin
            st_d.count = '0;
        end else if (edge_i) begin
            if (st_q.count == '0) begin
                st_d.count = st_q.reload;
            end else begin
                st_d.count = st_q.count - ONE;
                hit_zero   = (st_q.count == ONE);
            end
        end

        if (cmd_i.irq_enable)
            st_d.enable = 1'b1;

        if (cmd_i.irq_ack) begin
            st_d.enable = 1'b0;
            st_d.flag   = 1'b0;
        end else if (hit_zero && st_q.enable) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_i && !cmd_i.clear_count) |=> $stable(st_q.count));  // R2

    AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !cmd_i.clear_count && st_q.count == '0)
            |=> st_q.count == $past(st_q.reload));  // R3

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.clear_count |=> st_q.count == '0);  // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.irq_ack |=> (!st_q.flag && !st_q.enable));  // R7

    AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.irq_enable && !cmd_i.irq_ack) |=> st_q.enable);  // R8

    AST_NO_FLAG_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.enable && !st_q.flag) |=> !st_q.flag);  // R8

    AST_ZERO_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == '0 && !st_q.flag) |=> !st_q.flag);  // R9

endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer #(
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [CNT_W-1:0]  cpu_wdata,
    input  logic              ppu_a12,
    output logic              irq_n
);
    import scanirq_pkg::*;

    cmd_t cmd;
    logic line_rise;
    logic flag;

    scanirq_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .wr_i   (cpu_wr),
        .addr_i (cpu_addr),
        .cmd_o  (cmd)
    );

    scanirq_edge_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_LOW     (MIN_LOW)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (ppu_a12),
        .rise_o (line_rise)
    );

    scanirq_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (line_rise),
        .cmd_i  (cmd),
        .data_i (cpu_wdata),
        .flag_o (flag)
    );

    assign irq_n = ~flag;

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd.set_reload, cmd.clear_count, cmd.irq_ack, cmd.irq_enable}));  // R11

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !cmd.irq_ack) |=> !irq_n);  // R7

endmodule

// File: tb/tb_scanline_irq_timer.sv
module tb_scanline_irq_timer;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_LOW    = 4;
    localparam int LOW_CYC    = MIN_LOW + 6;
    localparam int HIGH_CYC   = 8;
    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_E = 2'd1;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [7:0]  data;
        logic        exp_irq_n;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 49;
    localparam vec_t VECS [NVEC] = '{
        '{OP_W, 16'hE001, 8'h00, 1'b1, 4'd8},   // R8 enable
        '{OP_W, 16'hC000, 8'h02, 1'b1, 4'd4},   // R4 reload 2
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd3},   // R3 load 2
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd2},   // R2 ->1
        '{OP_E, 16'h0000, 8'h00, 1'b0, 4'd6},   // R6 third edge fires
        '{OP_E, 16'h0000, 8'h00, 1'b0, 4'd7},   // R7 held low
        '{OP_W, 16'hE000, 8'h00, 1'b1, 4'd7},   // R7 ack
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd2},
        '{OP_W, 16'hE001, 8'h00, 1'b1, 4'd8},
        '{OP_W, 16'hC000, 8'h03, 1'b1, 4'd4},
        '{OP_W, 16'hC001, 8'hA5, 1'b1, 4'd5},   // R5 clear, data ignored
        '{OP_W, 16'hC000, 8'h04, 1'b1, 4'd4},
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd5},   // load 4
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd4},
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd4},
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd4},
        '{OP_E, 16'h0000, 8'h00, 1'b0, 4'd4},   // R4 fifth edge fires
        '{OP_W, 16'hE000, 8'h00, 1'b1, 4'd7},
        '{OP_W, 16'hE001, 8'h00, 1'b1, 4'd8},
        '{OP_W, 16'hC000, 8'h01, 1'b1, 4'd4},
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd3},   // load 1
        '{OP_W, 16'hC000, 8'h00, 1'b1, 4'd9},   // R9 reload 0
        '{OP_E, 16'h0000, 8'h00, 1'b0, 4'd9},   // R9 single fire
        '{OP_W, 16'hE000, 8'h00, 1'b1, 4'd7},
        '{OP_W, 16'hE001, 8'h00, 1'b1, 4'd8},
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd9},   // R9 no refire
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd9},
        '{OP_W, 16'hC000, 8'h01, 1'b1, 4'd9},
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd9},
        '{OP_E, 16'h0000, 8'h00, 1'b0, 4'd9},   // R9 resumes
        '{OP_W, 16'hE000, 8'h00, 1'b1, 4'd7},
        '{OP_W, 16'hE001, 8'h00, 1'b1, 4'd8},
        '{OP_W, 16'hC001, 8'h00, 1'b1, 4'd5},
        '{OP_W, 16'hC000, 8'h01, 1'b1, 4'd4},
        '{OP_W, 16'h8001, 8'h05, 1'b1, 4'd11},  // R11 other region
        '{OP_W, 16'h6000, 8'hFF, 1'b1, 4'd11},  // R11 other region
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd11},
        '{OP_E, 16'h0000, 8'h00, 1'b0, 4'd11},
        '{OP_W, 16'hE0F0, 8'h00, 1'b1, 4'd11},  // R11 ack mirror
        '{OP_W, 16'hFFFF, 8'h00, 1'b1, 4'd11},  // R11 enable mirror
        '{OP_W, 16'hD5F1, 8'h00, 1'b1, 4'd11},  // R11 clear mirror
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd11},
        '{OP_E, 16'h0000, 8'h00, 1'b0, 4'd11},
        '{OP_W, 16'hE000, 8'h00, 1'b1, 4'd7},
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd8},
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd8},   // R8 disabled, no irq
        '{OP_E, 16'h0000, 8'h00, 1'b1, 4'd6},
        '{OP_W, 16'hE001, 8'h00, 1'b1, 4'd8},
        '{OP_E, 16'h0000, 8'h00, 1'b0, 4'd6}    // R6 keeps running
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        ppu_a12 = 1'b0;
    logic        irq_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scanline_irq_timer #(
        .ADDR_W (16), .CNT_W (8), .SYNC_STAGES (2), .MIN_LOW (MIN_LOW)
    ) dut (
        .clk (clk), .rst_n (rst_n), .cpu_wr (cpu_wr), .cpu_addr (cpu_addr),
        .cpu_wdata (cpu_wdata), .ppu_a12 (ppu_a12), .irq_n (irq_n)
    );

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (irq_n !== exp) begin
            n_fails++;
            $display("FAIL %s irq_n actual=%b expected=%b", req, irq_n, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic a12_pulse();
        @(negedge clk);
        ppu_a12 = 1'b0;
        repeat (LOW_CYC) @(negedge clk);
        ppu_a12 = 1'b1;
        repeat (HIGH_CYC) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].op == OP_W) cpu_write(VECS[i].addr, VECS[i].data);
            else                    a12_pulse();
            n_checks++;
            if (irq_n !== VECS[i].exp_irq_n) begin
                n_fails++;
                $display("FAIL R%0d vector %0d irq_n actual=%b expected=%b",
                         VECS[i].req, i, irq_n, VECS[i].exp_irq_n);
            end
        end

        // R10: short low pulse rejected
        cpu_write(16'hE000, 8'h00);
        cpu_write(16'hE001, 8'h00);
        cpu_write(16'hC000, 8'h01);
        cpu_write(16'hC001, 8'h00);
        a12_pulse();
        check("R10", 1'b1);
        ppu_a12 = 1'b0;
        repeat (2) @(negedge clk);
        ppu_a12 = 1'b1;
        repeat (10) @(negedge clk);
        check("R10", 1'b1);
        a12_pulse();
        check("R10", 1'b0);
        cpu_write(16'hE000, 8'h00);

        // R2: falling edge alone does nothing
        cpu_write(16'hE001, 8'h00);
        cpu_write(16'hC001, 8'h00);
        a12_pulse();
        ppu_a12 = 1'b0;
        repeat (20) @(negedge clk);
        check("R2", 1'b1);
        ppu_a12 = 1'b1;
        repeat (10) @(negedge clk);
        check("R2", 1'b0);

        // R1: reset clears pending flag, reload and enable
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", 1'b1);
        cpu_write(16'hE001, 8'h00);
        a12_pulse();
        a12_pulse();
        check("R1", 1'b1);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule